// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Threshold Unit

This block sits beside the storage of a 36-bit-wide FIFO with a depth between 256 and 1,024 words. It holds two threshold offsets and turns the FIFO occupancy count, which it receives as an input, into registered almost-empty and almost-full flags. It does not hold the FIFO data or pointers. It runs on a single clock.

The offsets are set up during master reset. Three preset select codes load the same preset value into both thresholds. The fourth code leaves the thresholds open for the user to load. The user can shift them in serially through a data/enable pin pair, or write them as two words over the write data bus; a mode pin chooses between the two. Normal FIFO writes are held off until the thresholds have been loaded, and a done output shows when that has happened. A partial reset clears the flag state back to "empty" and keeps the loaded thresholds. A master reset reloads the whole configuration.

Top module: `afl_flag_unit`

## Requirements
- R1: While `rst` is high, `cfg_sel` chooses a preset that is loaded into both thresholds: 2'b00 loads 8, 2'b01 loads 16 and 2'b10 loads 64. On the cycle after reset is released, `prog_done` is 1.
- R2: If `cfg_sel` is 2'b11 during master reset, both thresholds are cleared and `prog_done` is 0 after release. The value of `cfg_serial` during that reset picks the load method: 1 for serial, 0 for parallel.
- R3: In serial mode, each clock edge with `ser_en` high shifts in one bit from `ser_data`. The first ten bits form the almost-empty threshold and the next ten form the almost-full threshold, each sent most significant bit first. `prog_done` rises on the edge that takes the 20th bit, and not before.
- R4: In parallel mode, the first `wr_en` cycle loads the almost-empty threshold from `wr_data[9:0]`, and the second loads the almost-full threshold the same way. `wr_data[35:10]` is ignored. `prog_done` rises on the edge that takes the second word.
- R5: `fifo_wr` equals `wr_en` when `prog_done` is 1 and is 0 otherwise.
- R6: One cycle after `occupancy` is presented, `almost_empty` is 1 exactly when `occupancy` is less than or equal to the almost-empty threshold.
- R7: One cycle after `occupancy` is presented, `almost_full` is 1 exactly when `DEPTH - occupancy` is less than or equal to the almost-full threshold.
- R8: While `part_rst` is high, the flags are forced to `almost_empty`=1 and `almost_full`=0. The thresholds, `prog_done` and any load in progress are not changed.
- R9: A master reset takes priority over a partial reset and over a load in progress, and reloads the configuration from `cfg_sel`.
- R10: In serial mode, `wr_en` has no effect on the thresholds. In parallel mode, `ser_en` has no effect on them.
- R11: Once `prog_done` is 1, it stays 1 until the next master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, synchronous, active high |
| part_rst | input | 1 | Partial reset, synchronous, active high |
| cfg_sel | input | 2 | Preset select, sampled during master reset |
| cfg_serial | input | 1 | Load method for user mode: 1 serial, 0 parallel |
| ser_data | input | 1 | Serial threshold bit |
| ser_en | input | 1 | Serial shift enable |
| wr_en | input | 1 | Write strobe from the write port |
| wr_data | input | 36 | Write data bus; bits 9:0 carry threshold words |
| occupancy | input | 11 | Current number of words held in the FIFO (0 to DEPTH) |
| almost_empty | output | 1 | Registered almost-empty flag |
| almost_full | output | 1 | Registered almost-full flag |
| prog_done | output | 1 | Thresholds loaded |
| fifo_wr | output | 1 | Write strobe passed on to the FIFO storage |

## Verification
The assertions assume that `occupancy` never goes above DEPTH. They also assume that `cfg_sel` is held steady for the whole of a master reset, so the value seen just before release is the one that was loaded. The stimulus drives `occupancy` only within 0 to DEPTH. It changes `cfg_sel` and `cfg_serial` only while reset is idle or at the start of a new reset pulse that lasts two cycles. The flag checks sweep every occupancy value for each threshold setting.

// File: rtl/afl_pkg.sv
package afl_pkg;
  typedef enum logic [1:0] {
    PRESET_A    = 2'b00,
    PRESET_B    = 2'b01,
    PRESET_C    = 2'b10,
    PRESET_USER = 2'b11
  } preset_e;
endpackage

// File: rtl/afl_offset_regs.sv
module afl_offset_regs
  import afl_pkg::*;
#(
  parameter int OFS_W  = 10,
  parameter int PRE_A  = 8,
  parameter int PRE_B  = 16,
  parameter int PRE_C  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  preset_e          cfg_sel,
  input  logic             cfg_serial,
  input  logic             ser_data,
  input  logic             ser_en,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_low,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs,
  output logic             done
);
  localparam int BITS = 2 * OFS_W;
  localparam int BCW  = $clog2(BITS + 1);
  localparam logic [OFS_W-1:0] VAL_A = OFS_W'(PRE_A);
  localparam logic [OFS_W-1:0] VAL_B = OFS_W'(PRE_B);
  localparam logic [OFS_W-1:0] VAL_C = OFS_W'(PRE_C);
  localparam logic [BCW-1:0]   LAST  = BCW'(BITS - 1);

  logic           mode_serial;
  logic           second_word;
  logic [BCW-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_serial <= cfg_serial;
      second_word <= 1'b0;
      bit_cnt     <= '0;
      case (cfg_sel)
        PRESET_A: begin ae_ofs <= VAL_A; af_ofs <= VAL_A; done <= 1'b1; end
        PRESET_B: begin ae_ofs <= VAL_B; af_ofs <= VAL_B; done <= 1'b1; end
        PRESET_C: begin ae_ofs <= VAL_C; af_ofs <= VAL_C; done <= 1'b1; end
        default:  begin ae_ofs <= '0;    af_ofs <= '0;    done <= 1'b0; end
      endcase
    end else if (!done) begin
      if (mode_serial) begin
        if (ser_en) begin
          {ae_ofs, af_ofs} <= {ae_ofs[OFS_W-2:0], af_ofs, ser_data};
          bit_cnt          <= bit_cnt + 1'b1;
          if (bit_cnt == LAST) done <= 1'b1;
        end
      end else if (wr_en) begin
        if (!second_word) begin
          ae_ofs      <= wr_low;
          second_word <= 1'b1;
        end else begin
          af_ofs <= wr_low;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/afl_flag_cmp.sv
module afl_flag_cmp #(
  parameter int DEPTH     = 1024,
  parameter int CNT_W     = 11,
  parameter int OFS_W     = 10,
  parameter bit FULL_SIDE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             part_rst,
  input  logic [CNT_W-1:0] occ,
  input  logic [OFS_W-1:0] ofs,
  output logic             flag
);
  localparam logic [CNT_W-1:0] DEP = CNT_W'(DEPTH);
  localparam logic             IDLE_VAL = !FULL_SIDE;

  logic [CNT_W-1:0] metric;

  generate
    if (FULL_SIDE) begin : g_free
      assign metric = DEP - occ;
    end else begin : g_used
      assign metric = occ;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || part_rst) flag <= IDLE_VAL;
    else                 flag <= (metric <= CNT_W'(ofs));
  end
endmodule

// File: rtl/afl_flag_unit.sv
module afl_flag_unit
  import afl_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 36,
  parameter int PRE_A  = 8,
  parameter int PRE_B  = 16,
  parameter int PRE_C  = 64,
  localparam int OFS_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              part_rst,
  input  logic [1:0]        cfg_sel,
  input  logic              cfg_serial,
  input  logic              ser_data,
  input  logic              ser_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  occupancy,
  output logic              almost_empty,
  output logic              almost_full,
  output logic              prog_done,
  output logic              fifo_wr
);
  logic [OFS_W-1:0] ae_ofs;
  logic [OFS_W-1:0] af_ofs;

  afl_offset_regs #(
    .OFS_W(OFS_W), .PRE_A(PRE_A), .PRE_B(PRE_B), .PRE_C(PRE_C)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_sel    (preset_e'(cfg_sel)),
    .cfg_serial (cfg_serial),
    .ser_data   (ser_data),
    .ser_en     (ser_en),
    .wr_en      (wr_en),
    .wr_low     (wr_data[OFS_W-1:0]),
    .ae_ofs     (ae_ofs),
    .af_ofs     (af_ofs),
    .done       (prog_done)
  );

  afl_flag_cmp #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W), .FULL_SIDE(1'b0)
  ) u_ae (
    .clk(clk), .rst(rst), .part_rst(part_rst),
    .occ(occupancy), .ofs(ae_ofs), .flag(almost_empty)
  );

  afl_flag_cmp #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W), .FULL_SIDE(1'b1)
  ) u_af (
    .clk(clk), .rst(rst), .part_rst(part_rst),
    .occ(occupancy), .ofs(af_ofs), .flag(almost_full)
  );

  assign fifo_wr = wr_en & prog_done;
endmodule

// File: rtl/afl_flag_checker.sv
module afl_flag_checker #(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             part_rst,
  input logic [1:0]       cfg_sel,
  input logic [CNT_W-1:0] occupancy,
  input logic             almost_empty,
  input logic             almost_full,
  input logic             prog_done
);
  a_r1_preset_done: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && $past(cfg_sel) != 2'b11) |-> prog_done);

  a_r2_user_not_done: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && $past(cfg_sel) == 2'b11) |-> !prog_done);

  a_r6_zero_is_almost_empty: assert property (@(posedge clk) disable iff (rst)
    (!part_rst && occupancy == '0) |=> almost_empty);

  a_r7_full_is_almost_full: assert property (@(posedge clk) disable iff (rst)
    (!part_rst && occupancy == CNT_W'(DEPTH)) |=> almost_full);

  a_r8_partial_flags: assert property (@(posedge clk) disable iff (rst)
    part_rst |=> (almost_empty && !almost_full));

  a_r8_partial_keeps_done: assert property (@(posedge clk) disable iff (rst)
    (part_rst && prog_done) |=> prog_done);

  a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
    prog_done |=> prog_done);
endmodule

bind afl_flag_unit afl_flag_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_afl_chk (
  .clk(clk), .rst(rst), .part_rst(part_rst), .cfg_sel(cfg_sel),
  .occupancy(occupancy), .almost_empty(almost_empty),
  .almost_full(almost_full), .prog_done(prog_done)
);

// File: tb/test_afl_flag_unit.sv
`timescale 1ns/1ps
module test_afl_flag_unit;
  localparam int DEPTH = 1024;
  localparam int CW    = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          part_rst = 1'b0;
  logic [1:0]    cfg_sel = 2'b00;
  logic          cfg_serial = 1'b0;
  logic          ser_data = 1'b0;
  logic          ser_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [35:0]   wr_data = '0;
  logic [CW-1:0] occupancy = '0;
  logic          almost_empty, almost_full, prog_done, fifo_wr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  afl_flag_unit i_afl_flag_unit (
    .clk(clk), .rst(rst), .part_rst(part_rst), .cfg_sel(cfg_sel),
    .cfg_serial(cfg_serial), .ser_data(ser_data), .ser_en(ser_en),
    .wr_en(wr_en), .wr_data(wr_data), .occupancy(occupancy),
    .almost_empty(almost_empty), .almost_full(almost_full),
    .prog_done(prog_done), .fifo_wr(fifo_wr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic master_reset(input logic [1:0] sel, input logic serial);
    @(negedge clk);
    rst = 1'b1; cfg_sel = sel; cfg_serial = serial;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R6 R7: sweep all occupancy values against arithmetic expectations
  task automatic sweep(input int ae, input int af, input string tag);
    int bad = 0;
    for (int o = 0; o <= DEPTH; o++) begin
      occupancy = CW'(o);
      @(negedge clk);
      checks += 2;
      if (almost_empty != (o <= ae)) begin
        bad++; errors++;
        $display("FAIL R6 %s occ %0d: actual %0b expected %0b", tag, o, almost_empty, (o <= ae));
      end
      if (almost_full != ((DEPTH - o) <= af)) begin
        bad++; errors++;
        $display("FAIL R7 %s occ %0d: actual %0b expected %0b", tag, o, almost_full, ((DEPTH - o) <= af));
      end
      if (bad > 8) break;
    end
    occupancy = '0;
  endtask

  task automatic serial_load(input int ae, input int af);
    for (int i = 0; i < 20; i++) begin
      ser_en   = 1'b1;
      ser_data = (i < 10) ? ae[9 - i] : af[19 - i];
      wr_en    = 1'b1;
      #1 chk("R5 fifo_wr blocked while loading", fifo_wr, 0);
      @(negedge clk);
      if (i == 18) chk("R3 not done after 19 bits", prog_done, 0);
    end
    ser_en = 1'b0; wr_en = 1'b0;
    chk("R3 done after 20 bits", prog_done, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state done", prog_done, 1);
    chk("R6 reset state ae", almost_empty, 1);
    chk("R7 reset state af", almost_full, 0);

    // R1 presets
    master_reset(2'b00, 1'b0); @(negedge clk);
    chk("R1 preset 8 done", prog_done, 1);
    sweep(8, 8, "preset8");
    master_reset(2'b01, 1'b1); sweep(16, 16, "preset16");
    master_reset(2'b10, 1'b0); sweep(64, 64, "preset64");

    // R5 writes pass when done
    wr_en = 1'b1; #1 chk("R5 fifo_wr passes when done", fifo_wr, 1);
    wr_en = 1'b0; #1 chk("R5 fifo_wr idle", fifo_wr, 0);

    // R2 R3 R10 serial user load; wr_en pulses must not disturb thresholds
    master_reset(2'b11, 1'b1); @(negedge clk);
    chk("R2 user mode not done", prog_done, 0);
    serial_load(5, 300);
    sweep(5, 300, "serial");

    // R8 partial reset keeps thresholds
    occupancy = CW'(DEPTH);
    @(negedge clk);
    part_rst = 1'b1;
    @(negedge clk);
    chk("R8 partial ae forced", almost_empty, 1);
    chk("R8 partial af forced", almost_full, 0);
    chk("R8 partial keeps done", prog_done, 1);
    part_rst = 1'b0;
    sweep(5, 300, "after_partial");

    // R2 R4 R10 parallel load; serial pulses ignored
    master_reset(2'b11, 1'b0); @(negedge clk);
    chk("R2 parallel not done", prog_done, 0);
    for (int i = 0; i < 25; i++) begin
      ser_en = 1'b1; ser_data = i[0];
      @(negedge clk);
    end
    ser_en = 1'b0;
    chk("R10 serial ignored in parallel mode", prog_done, 0);
    wr_en = 1'b1; wr_data = {26'h2ABCDEF, 10'd100};
    #1 chk("R5 fifo_wr blocked parallel", fifo_wr, 0);
    @(negedge clk);
    chk("R4 not done after first word", prog_done, 0);
    wr_data = {26'h3FFFFFF, 10'd7};
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 done after second word", prog_done, 1);
    sweep(100, 7, "parallel");

    // R9 master reset overrides partial reset and a load in progress
    master_reset(2'b11, 1'b1);
    for (int i = 0; i < 7; i++) begin
      ser_en = 1'b1; ser_data = 1'b1; @(negedge clk);
    end
    ser_en = 1'b0;
    part_rst = 1'b1;
    master_reset(2'b01, 1'b0);
    part_rst = 1'b0;
    @(negedge clk);
    chk("R9 preset reloaded done", prog_done, 1);
    chk("R11 done held", prog_done, 1);
    sweep(16, 16, "reload16");

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule